// File: doc/BRIEF.md
# Regulator Fault Debounce and Shutdown Supervisor

This block watches the digital fault indicators of several step-down regulator channels and decides when a fault becomes an interrupt event and when it shuts a channel down. Each channel supplies two indicators. The first shows that peak-current regulation is active. The second is a comparator that shows the output sits below its short-circuit level. A single die-overtemperature indicator is shared by every channel. All durations are counted in ticks of a periodic strobe, nominally one every microsecond, so the debounce times are parameters and not hard-wired clock counts.

Software sets or clears the enabled status of a channel with per-channel request pulses. After a channel is enabled, a one-shot check is taken a fixed number of ticks later: a low output at that moment means a short circuit. Once that check has passed, a low output that lasts a debounce time means an overload. Either fault drops the channel, issues a disable command and raises the channel's short-circuit event. A current-limit condition that lasts its own debounce time only raises an event, and regulation carries on. Overtemperature switches every channel off at once. A channel switched off by any cause stays off until software enables it again.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After reset, every enabled status bit, disable command and event output is 0.
- R2: An enable request sets the channel's status bit in the next cycle, and a clear request drops it without a disable command. A channel switched off by a fault stays off, whatever its indicators do, until a new enable request.
- R3: While a channel is enabled and current limit is active on every tick, the tick that brings the count to ILIM_TICKS produces a one-cycle current-limit event in the cycle after that clock edge. No second event follows until the indicator has gone inactive.
- R4: If the current-limit indicator goes inactive in any cycle before the count is reached, the count restarts from zero.
- R5: A current-limit event leaves the channel enabled and issues no disable command.
- R6: If the output-low indicator is set on the tick that completes SC_TICKS ticks after enable, then in the cycle after that edge the short-circuit event and the disable command each pulse for one cycle, and the status bit is 0.
- R7: Output-low during the first SC_TICKS-1 ticks after enable causes no fault, and it contributes nothing to the overload count.
- R8: After the start-up check has passed, output-low on ILIM-independent ticks for OVL_TICKS consecutive ticks gives the same shutdown as R6. Any cycle with the indicator clear restarts that count.
- R9: A cycle with overtemperature set clears every status bit at the next edge. It pulses the disable command only for channels that were enabled, and pulses the thermal event once per rising edge of the indicator. Enable requests are ignored while overtemperature stays set.
- R10: The current-limit indicator of a disabled channel produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per time unit |
| en_set | input | NUM_CH | Per-channel enable request pulses |
| en_clr | input | NUM_CH | Per-channel software disable request pulses |
| ilim_act | input | NUM_CH | Current-limit regulation active, per channel |
| vout_low | input | NUM_CH | Output below short-circuit level, per channel |
| die_hot | input | 1 | Shared overtemperature indicator |
| ch_en | output | NUM_CH | Enabled status bit per channel |
| ilim_evt | output | NUM_CH | Current-limit event pulse per channel |
| sc_evt | output | NUM_CH | Short-circuit/overload event pulse per channel |
| off_cmd | output | NUM_CH | Disable command pulse per channel |
| therm_evt | output | 1 | Thermal shutdown event pulse |

## Verification
Every result is registered once. An enable request, the final qualifying tick of a debounce or check window, and an overtemperature edge therefore show their effect in the cycle right after the clock edge that samples them, and pulses fall again one cycle later. The bench drives inputs and samples outputs on the falling clock edge. It issues ticks one at a time and checks the pulse exactly one half-cycle after the edge that consumes the last tick, then checks that it has fallen on the next falling edge. Running event counters confirm that no extra pulse appears between these points.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;

  // Bits needed to hold a count that saturates at lim.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dwell_counter.sv
module dwell_counter
  import rail_fault_pkg::*;
#(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic tick,
  output logic hit,
  output logic full
);
  localparam int W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cond) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign hit  = cond && tick && (cnt == LAST);
  assign full = (cnt == TOP);

  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (rst)
    !cond |=> (cnt == '0));
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/rail_channel.sv
module rail_channel #(
  parameter int ILIM_TICKS = 20,
  parameter int SC_TICKS   = 1000,
  parameter int OVL_TICKS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic kill,
  input  logic en_set,
  input  logic en_clr,
  input  logic ilim,
  input  logic vlow,
  output logic ch_en,
  output logic ilim_evt,
  output logic sc_evt,
  output logic off_cmd
);
  logic ilim_hit, ilim_full;
  logic win_hit, win_done;
  logic ovl_hit, ovl_full;
  logic short_now, fault_now;

  dwell_counter #(.LIMIT(ILIM_TICKS)) u_ilim (
    .clk(clk), .rst(rst), .cond(ch_en && ilim), .tick(tick),
    .hit(ilim_hit), .full(ilim_full));

  dwell_counter #(.LIMIT(SC_TICKS)) u_window (
    .clk(clk), .rst(rst), .cond(ch_en), .tick(tick),
    .hit(win_hit), .full(win_done));

  dwell_counter #(.LIMIT(OVL_TICKS)) u_ovl (
    .clk(clk), .rst(rst), .cond(ch_en && win_done && vlow), .tick(tick),
    .hit(ovl_hit), .full(ovl_full));

  assign short_now = win_hit && vlow;
  assign fault_now = short_now || ovl_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en    <= 1'b0;
      ilim_evt <= 1'b0;
      sc_evt   <= 1'b0;
      off_cmd  <= 1'b0;
    end else begin
      ilim_evt <= ilim_hit && !kill;
      sc_evt   <= 1'b0;
      off_cmd  <= 1'b0;
      if (kill) begin
        off_cmd <= ch_en;
        ch_en   <= 1'b0;
      end else if (ch_en && fault_now) begin
        sc_evt  <= 1'b1;
        off_cmd <= 1'b1;
        ch_en   <= 1'b0;
      end else if (en_clr) begin
        ch_en <= 1'b0;
      end else if (en_set) begin
        ch_en <= 1'b1;
      end
    end
  end

  assert_ilim_single_R3: assert property (@(posedge clk) disable iff (rst)
    ilim_evt |=> !ilim_evt);
  assert_fault_drops_R6: assert property (@(posedge clk) disable iff (rst)
    sc_evt |-> (off_cmd && !ch_en));
  assert_off_means_down_R5: assert property (@(posedge clk) disable iff (rst)
    off_cmd |-> !ch_en);
  assert_enable_by_request_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_en) |-> $past(en_set));
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int NUM_CH     = 4,
  parameter int ILIM_TICKS = 20,
  parameter int SC_TICKS   = 1000,
  parameter int OVL_TICKS  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NUM_CH-1:0] en_set,
  input  logic [NUM_CH-1:0] en_clr,
  input  logic [NUM_CH-1:0] ilim_act,
  input  logic [NUM_CH-1:0] vout_low,
  input  logic              die_hot,
  output logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] ilim_evt,
  output logic [NUM_CH-1:0] sc_evt,
  output logic [NUM_CH-1:0] off_cmd,
  output logic              therm_evt
);
  logic hot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q     <= 1'b0;
      therm_evt <= 1'b0;
    end else begin
      hot_q     <= die_hot;
      therm_evt <= die_hot && !hot_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    rail_channel #(
      .ILIM_TICKS(ILIM_TICKS), .SC_TICKS(SC_TICKS), .OVL_TICKS(OVL_TICKS)
    ) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .kill(die_hot),
      .en_set(en_set[i]), .en_clr(en_clr[i]),
      .ilim(ilim_act[i]), .vlow(vout_low[i]),
      .ch_en(ch_en[i]), .ilim_evt(ilim_evt[i]),
      .sc_evt(sc_evt[i]), .off_cmd(off_cmd[i]));
  end

  assert_thermal_all_off_R9: assert property (@(posedge clk) disable iff (rst)
    die_hot |=> (ch_en == '0));
  assert_thermal_single_R9: assert property (@(posedge clk) disable iff (rst)
    therm_evt |=> !therm_evt);
endmodule

// File: tb/tb_rail_fault_supervisor.sv
module tb_rail_fault_supervisor;
  localparam int N    = 4;
  localparam int ILIM = 5;
  localparam int SC   = 8;
  localparam int OVL  = 6;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, die_hot = 1'b0;
  logic [N-1:0] en_set = '0, en_clr = '0, ilim_act = '0, vout_low = '0;
  logic [N-1:0] ch_en, ilim_evt, sc_evt, off_cmd;
  logic therm_evt;
  int n_chk = 0, n_bad = 0;
  int ilim_cnt [N];
  int sc_cnt [N];
  int off_cnt [N];
  int therm_cnt = 0;

  always #2 clk = ~clk;

  rail_fault_supervisor #(.NUM_CH(N), .ILIM_TICKS(ILIM), .SC_TICKS(SC), .OVL_TICKS(OVL)) dut (
    .clk(clk), .rst(rst), .tick(tick), .en_set(en_set), .en_clr(en_clr),
    .ilim_act(ilim_act), .vout_low(vout_low), .die_hot(die_hot),
    .ch_en(ch_en), .ilim_evt(ilim_evt), .sc_evt(sc_evt), .off_cmd(off_cmd),
    .therm_evt(therm_evt));

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin ilim_cnt[i] = 0; sc_cnt[i] = 0; off_cnt[i] = 0; end
      therm_cnt = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        ilim_cnt[i] += int'(ilim_evt[i]);
        sc_cnt[i]   += int'(sc_evt[i]);
        off_cnt[i]  += int'(off_cmd[i]);
      end
      therm_cnt += int'(therm_evt);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic last_tick;
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic enable(input logic [N-1:0] m);
    en_set = m; @(negedge clk); en_set = '0;
  endtask

  task automatic t_reset;
    chk("R1 ch_en", int'(ch_en), 0);
    chk("R1 events", int'({ilim_evt, sc_evt, off_cmd, therm_evt}), 0);
  endtask

  task automatic t_ilim;
    enable(4'b0001);
    chk("R2 enable", int'(ch_en[0]), 1);
    ilim_act[0] = 1'b1;
    ticks(ILIM - 1);
    chk("R3 early", ilim_cnt[0], 0);
    last_tick;
    chk("R3 pulse", int'(ilim_evt[0]), 1);
    @(negedge clk);
    chk("R3 pulse width", int'(ilim_evt[0]), 0);
    ticks(3);
    chk("R3 once", ilim_cnt[0], 1);
    chk("R5 still on", int'(ch_en[0]), 1);
    chk("R5 no off", off_cnt[0] + sc_cnt[0], 0);
    ilim_act[0] = 1'b0; @(negedge clk);
    ilim_act[0] = 1'b1;
    ticks(ILIM - 2);
    ilim_act[0] = 1'b0; @(negedge clk);
    ilim_act[0] = 1'b1;
    ticks(ILIM - 1);
    chk("R4 restart", ilim_cnt[0], 1);
    last_tick; @(negedge clk);
    chk("R4 after full", ilim_cnt[0], 2);
    ilim_act[0] = 1'b0;
  endtask

  task automatic t_disabled_ilim;
    ilim_act[3] = 1'b1;
    ticks(ILIM + 2);
    chk("R10 ignored", ilim_cnt[3], 0);
    ilim_act[3] = 1'b0;
  endtask

  task automatic t_short;
    vout_low[1] = 1'b1;
    enable(4'b0010);
    ticks(SC - 1);
    chk("R6 before check", int'(ch_en[1]), 1);
    last_tick;
    chk("R6 sc_evt", int'(sc_evt[1]), 1);
    chk("R6 off_cmd", int'(off_cmd[1]), 1);
    chk("R6 status", int'(ch_en[1]), 0);
    vout_low[1] = 1'b0;
    @(negedge clk);
    chk("R6 width", int'(sc_evt[1] | off_cmd[1]), 0);
    ticks(SC + 2);
    chk("R2 stays off", int'(ch_en[1]), 0);
    enable(4'b0010);
    chk("R2 re-enable", int'(ch_en[1]), 1);
  endtask

  task automatic t_overload;
    vout_low[2] = 1'b1;
    enable(4'b0100);
    ticks(SC - 1);
    vout_low[2] = 1'b0;
    ticks(1);
    chk("R7 no short", sc_cnt[2], 0);
    vout_low[2] = 1'b1;
    ticks(OVL - 1);
    chk("R7 window not counted", int'(ch_en[2]), 1);
    vout_low[2] = 1'b0; @(negedge clk);
    vout_low[2] = 1'b1;
    ticks(OVL - 1);
    chk("R8 restart", int'(ch_en[2]), 1);
    last_tick;
    chk("R8 sc_evt", int'(sc_evt[2]), 1);
    chk("R8 status", int'(ch_en[2]), 0);
    vout_low[2] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_soft_clear;
    enable(4'b0001);
    en_clr = 4'b0001; @(negedge clk); en_clr = '0;
    chk("R2 clear", int'(ch_en[0]), 0);
    chk("R2 clear no off", off_cnt[0], 0);
  endtask

  task automatic t_thermal;
    enable(4'b0001);
    die_hot = 1'b1; @(negedge clk);
    chk("R9 therm_evt", int'(therm_evt), 1);
    chk("R9 all off", int'(ch_en), 0);
    chk("R9 off_cmd", int'(off_cmd), 3);
    enable(4'b1111);
    chk("R9 pulse", int'(therm_evt), 0);
    chk("R9 enable blocked", int'(ch_en), 0);
    ticks(2);
    chk("R9 once", therm_cnt, 1);
    die_hot = 1'b0; @(negedge clk);
    enable(4'b0001);
    chk("R9 recover", int'(ch_en[0]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_ilim;
    t_disabled_ilim;
    t_short;
    t_overload;
    t_soft_clear;
    t_thermal;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule